// File: doc/BRIEF.md
# Result Latency Scoreboard with Pairwise Forwarding Overrides

This block keeps, for every architected destination tag, the class of the last operation that writes it and the cycle in which that operation was dispatched. Later consumers present their source tags together with their own operation class. The block answers with a registered stall flag that stays high until every enabled source has had time to produce its result. The wait normally comes from the producer's class. A small set of producer/consumer class pairs replaces that wait with a forwarding latency of their own, shorter or longer. So the same producer can be ready for one consumer and still pending for another.

One dispatch write port records producers. Two query ports, each with two source slots, serve consumers. A free-running cycle counter is visible at the ports. A synchronous clear-all marks every tag ready. This serves as a simple recovery step after a flush. A background sweep retires entries whose age has passed the largest possible latency, so old results stay ready when the counter wraps.

Top module: `lat_scoreboard`

## Requirements
- R1: After `rst`, and in the cycle after `flush` is sampled high, every tag reads as ready. A dispatch sampled in the same cycle as `flush` is dropped.
- R2: Class codes are 4 bits: 1 simple ALU (2 cycles), 2 load (4), 3 single-precision float load (7), 4 multiply (5), 5 record-form multiply (5), 6 divide (12), 7 record-form divide (12), 8 matrix-accumulate (9), 9 store-with-update address result (2), 10 record-form shift/count (3), 11 condition-register logical (2), 12 condition-register move (2). With no override, a consumer sees the value in parentheses.
- R3: Class 0 (ordinary store, no register result) and codes 13 to 15 write nothing. The tag keeps its earlier producer and dispatch cycle.
- R4: A multiply (class 4 or 5) that feeds a multiply consumer (class 4 or 5) gives a latency of 4.
- R5: A matrix-accumulate producer that feeds a matrix-accumulate consumer gives a latency of 4.
- R6: For a consumer of class 11 or 12, a class 1 producer gives 4 and a class 10 producer gives 5.
- R7: For a consumer of class 11 or 12, a class 5 producer gives 7 and a class 7 producer gives 14.
- R8: A query stalls when any source whose enable bit is set is not yet ready. Sources with a clear enable bit are ignored. A port whose valid input is low reports no stall.
- R9: A newer dispatch to a tag replaces the older producer entirely.
- R10: A query that names a tag being dispatched at the same clock edge stalls.
- R11: `cycle_o` increments by one every cycle after reset. Take a dispatch sampled when `cycle_o` = N and a query sampled when `cycle_o` = M. The stall result, visible after that query edge, is low exactly when M-N (mod 2^CNT_W) is at least the latency.
- R12: A tag dispatched more than NUM_TAGS+14 cycles earlier reads ready, even when the counter has wrapped since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear-all: every tag becomes ready |
| disp_valid | input | 1 | Dispatch write enable |
| disp_tag | input | TAG_W | Destination tag being written |
| disp_class | input | 4 | Producer class code |
| q_valid | input | NQ | Per-port query valid |
| q_class | input | NQ*4 | Per-port consumer class, port p at bits [4p+3:4p] |
| q_src | input | NQ*NS*TAG_W | Source tags, port p slot s at index p*NS+s |
| q_src_en | input | NQ*NS | Source enable, same indexing as q_src |
| q_stall | output | NQ | Registered per-port stall flag |
| cycle_o | output | CNT_W | Free-running cycle counter |

## Verification
The hardest case to reach is a tag that is still formally pending when the cycle counter wraps. Its raw age difference then falls back below its latency and would read as a stall again. The stimulus dispatches a record-form divide and then waits 261 cycles before querying with a condition-register consumer. The wrapped age is only 5 cycles, so only the background sweep can make the answer ready. Each forwarding override is also probed one cycle before and exactly at its latency, and set against the same producer's default latency with a non-matching consumer.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int CLS_W   = 4;
  localparam int LAT_W   = 4;
  localparam int MAX_LAT = 14;

  typedef enum logic [CLS_W-1:0] {
    OPC_NONE      = 4'd0,
    OPC_ALU       = 4'd1,
    OPC_LOAD      = 4'd2,
    OPC_LOAD_SP   = 4'd3,
    OPC_MUL       = 4'd4,
    OPC_MUL_REC   = 4'd5,
    OPC_DIV       = 4'd6,
    OPC_DIV_REC   = 4'd7,
    OPC_MMA       = 4'd8,
    OPC_ST_UPD    = 4'd9,
    OPC_SHIFT_REC = 4'd10,
    OPC_CR_LOGIC  = 4'd11,
    OPC_CR_MOVE   = 4'd12
  } op_class_e;

  // True when the class produces a register result
  function automatic logic cls_writes(input logic [CLS_W-1:0] c);
    return (c != OPC_NONE) && (c <= OPC_CR_MOVE);
  endfunction

  function automatic logic is_cr_cons(input logic [CLS_W-1:0] c);
    return (c == OPC_CR_LOGIC) || (c == OPC_CR_MOVE);
  endfunction

  function automatic logic is_mul(input logic [CLS_W-1:0] c);
    return (c == OPC_MUL) || (c == OPC_MUL_REC);
  endfunction

  function automatic logic [LAT_W-1:0] base_lat(input logic [CLS_W-1:0] c);
    case (c)
      OPC_ALU:       return 4'd2;
      OPC_LOAD:      return 4'd4;
      OPC_LOAD_SP:   return 4'd7;
      OPC_MUL:       return 4'd5;
      OPC_MUL_REC:   return 4'd5;
      OPC_DIV:       return 4'd12;
      OPC_DIV_REC:   return 4'd12;
      OPC_MMA:       return 4'd9;
      OPC_ST_UPD:    return 4'd2;
      OPC_SHIFT_REC: return 4'd3;
      OPC_CR_LOGIC:  return 4'd2;
      OPC_CR_MOVE:   return 4'd2;
      default:       return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/sb_cycle_ctr.sv
module sb_cycle_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end

  // R11: counter advances by exactly one per cycle outside reset
  assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (now == CNT_W'($past(now) + 1'b1)));
endmodule

// File: rtl/sb_latency_lut.sv
module sb_latency_lut
  import lsb_pkg::*;
(
  input  logic [CLS_W-1:0] prod,
  input  logic [CLS_W-1:0] cons,
  output logic [LAT_W-1:0] lat
);
  always_comb begin
    lat = base_lat(prod);
    if (is_mul(prod) && is_mul(cons)) begin
      lat = 4'd4;
    end else if ((prod == OPC_MMA) && (cons == OPC_MMA)) begin
      lat = 4'd4;
    end else if (is_cr_cons(cons)) begin
      case (prod)
        OPC_ALU:       lat = 4'd4;
        OPC_SHIFT_REC: lat = 4'd5;
        OPC_MUL_REC:   lat = 4'd7;
        OPC_DIV_REC:   lat = 4'd14;
        default:       lat = base_lat(prod);
      endcase
    end
  end
endmodule

// File: rtl/sb_entry_file.sv
module sb_entry_file
  import lsb_pkg::*;
#(
  parameter int NUM_TAGS = 32,
  parameter int CNT_W    = 8,
  parameter int NR       = 4,
  localparam int TAG_W   = $clog2(NUM_TAGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [CLS_W-1:0] wr_cls,
  input  logic [CNT_W-1:0] now,
  input  logic [TAG_W-1:0] rd_tag     [NR],
  output logic             rd_settled [NR],
  output logic [CLS_W-1:0] rd_cls     [NR],
  output logic [CNT_W-1:0] rd_issue   [NR],
  output logic             wr_take
);
  logic [NUM_TAGS-1:0] settled;
  logic [CLS_W-1:0]    cls_mem   [NUM_TAGS];
  logic [CNT_W-1:0]    issue_mem [NUM_TAGS];
  logic [TAG_W-1:0]    sweep_idx;
  logic [CNT_W-1:0]    sweep_age;
  logic                sweep_hit;

  assign wr_take   = wr_en && cls_writes(wr_cls) && !flush;
  assign sweep_age = now - issue_mem[sweep_idx];
  assign sweep_hit = !settled[sweep_idx] && (sweep_age >= CNT_W'(MAX_LAT));

  // Payload arrays: no reset, single write port
  always_ff @(posedge clk) begin
    if (wr_take) begin
      cls_mem[wr_tag]   <= wr_cls;
      issue_mem[wr_tag] <= now;
    end
  end

  // Ready bits: clear-all on reset or flush; dispatch beats the sweep
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      settled <= '1;
    end else begin
      if (sweep_hit) settled[sweep_idx] <= 1'b1;
      if (wr_take)   settled[wr_tag]    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                    sweep_idx <= '0;
    else if (sweep_idx == TAG_W'(NUM_TAGS - 1)) sweep_idx <= '0;
    else                                        sweep_idx <= sweep_idx + 1'b1;
  end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    assign rd_settled[r] = settled[rd_tag[r]];
    assign rd_cls[r]     = cls_mem[rd_tag[r]];
    assign rd_issue[r]   = issue_mem[rd_tag[r]];
  end

  // R1: clear-all leaves every tag ready
  assert_flush_clears_R1: assert property (@(posedge clk) disable iff (rst)
    flush |=> (&settled));

  // R9: an accepted dispatch makes the tag pending with the current cycle
  assert_write_pending_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush && cls_writes(wr_cls)) |=>
      (!settled[$past(wr_tag)] && (issue_mem[$past(wr_tag)] == $past(now))));

  // R3: a non-writing class leaves a pending entry's dispatch cycle alone
  assert_none_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cls_writes(wr_cls) && !settled[wr_tag]) |=>
      (issue_mem[$past(wr_tag)] == $past(issue_mem[wr_tag])));
endmodule

// File: rtl/sb_query_port.sv
module sb_query_port
  import lsb_pkg::*;
#(
  parameter int NS    = 2,
  parameter int TAG_W = 5,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_valid,
  input  logic [CLS_W-1:0] q_cls,
  input  logic [TAG_W-1:0] src        [NS],
  input  logic [NS-1:0]    src_en,
  input  logic [CNT_W-1:0] now,
  input  logic             rd_settled [NS],
  input  logic [CLS_W-1:0] rd_cls     [NS],
  input  logic [CNT_W-1:0] rd_issue   [NS],
  input  logic             wr_take,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             stall
);
  logic [NS-1:0] src_stall;

  for (genvar s = 0; s < NS; s++) begin : g_src
    logic [LAT_W-1:0] lat;
    logic [CNT_W-1:0] age;
    logic             same_edge;

    sb_latency_lut u_lut (
      .prod (rd_cls[s]),
      .cons (q_cls),
      .lat  (lat)
    );

    assign age       = now - rd_issue[s];
    assign same_edge = wr_take && (wr_tag == src[s]);
    assign src_stall[s] = src_en[s] &&
                          (same_edge || (!rd_settled[s] && (age < CNT_W'(lat))));
  end

  always_ff @(posedge clk) begin
    if (rst) stall <= 1'b0;
    else     stall <= q_valid && (|src_stall);
  end

  // R8: an idle port never reports a stall
  assert_idle_no_stall_R8: assert property (@(posedge clk) disable iff (rst)
    !q_valid |=> !stall);

  // R8: a query with every source disabled is ready
  assert_no_src_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (q_valid && (src_en == '0)) |=> !stall);
endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard
  import lsb_pkg::*;
#(
  parameter int NUM_TAGS = 32,
  parameter int CNT_W    = 8,
  parameter int NQ       = 2,
  parameter int NS       = 2,
  localparam int TAG_W   = $clog2(NUM_TAGS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   disp_valid,
  input  logic [TAG_W-1:0]       disp_tag,
  input  logic [CLS_W-1:0]       disp_class,
  input  logic [NQ-1:0]          q_valid,
  input  logic [NQ*CLS_W-1:0]    q_class,
  input  logic [NQ*NS*TAG_W-1:0] q_src,
  input  logic [NQ*NS-1:0]       q_src_en,
  output logic [NQ-1:0]          q_stall,
  output logic [CNT_W-1:0]       cycle_o
);
  localparam int NR = NQ * NS;

  logic [CNT_W-1:0] now;
  logic [TAG_W-1:0] rd_tag     [NR];
  logic             rd_settled [NR];
  logic [CLS_W-1:0] rd_cls     [NR];
  logic [CNT_W-1:0] rd_issue   [NR];
  logic             wr_take;

  sb_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk (clk),
    .rst (rst),
    .now (now)
  );

  assign cycle_o = now;

  for (genvar r = 0; r < NR; r++) begin : g_tag
    assign rd_tag[r] = q_src[r*TAG_W +: TAG_W];
  end

  sb_entry_file #(
    .NUM_TAGS (NUM_TAGS),
    .CNT_W    (CNT_W),
    .NR       (NR)
  ) u_file (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .wr_en      (disp_valid),
    .wr_tag     (disp_tag),
    .wr_cls     (disp_class),
    .now        (now),
    .rd_tag     (rd_tag),
    .rd_settled (rd_settled),
    .rd_cls     (rd_cls),
    .rd_issue   (rd_issue),
    .wr_take    (wr_take)
  );

  for (genvar p = 0; p < NQ; p++) begin : g_port
    logic [TAG_W-1:0] p_src     [NS];
    logic             p_settled [NS];
    logic [CLS_W-1:0] p_cls     [NS];
    logic [CNT_W-1:0] p_issue   [NS];

    for (genvar s = 0; s < NS; s++) begin : g_map
      assign p_src[s]     = rd_tag[p*NS+s];
      assign p_settled[s] = rd_settled[p*NS+s];
      assign p_cls[s]     = rd_cls[p*NS+s];
      assign p_issue[s]   = rd_issue[p*NS+s];
    end

    sb_query_port #(
      .NS    (NS),
      .TAG_W (TAG_W),
      .CNT_W (CNT_W)
    ) u_port (
      .clk        (clk),
      .rst        (rst),
      .q_valid    (q_valid[p]),
      .q_cls      (q_class[p*CLS_W +: CLS_W]),
      .src        (p_src),
      .src_en     (q_src_en[p*NS +: NS]),
      .now        (now),
      .rd_settled (p_settled),
      .rd_cls     (p_cls),
      .rd_issue   (p_issue),
      .wr_take    (wr_take),
      .wr_tag     (disp_tag),
      .stall      (q_stall[p])
    );
  end

  // R10: same-edge dispatch and query of one tag on port 0 slot 0 stalls
  assert_same_edge_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !flush && cls_writes(disp_class) && q_valid[0] &&
     q_src_en[0] && (q_src[TAG_W-1:0] == disp_tag)) |=> q_stall[0]);
endmodule

// File: tb/tb_lat_scoreboard.sv
module tb_lat_scoreboard;
  import lsb_pkg::*;

  localparam int NUM_TAGS = 32;
  localparam int CNT_W    = 8;
  localparam int NQ       = 2;
  localparam int NS       = 2;
  localparam int TAG_W    = $clog2(NUM_TAGS);

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   flush = 1'b0;
  logic                   disp_valid = 1'b0;
  logic [TAG_W-1:0]       disp_tag = '0;
  logic [CLS_W-1:0]       disp_class = '0;
  logic [NQ-1:0]          q_valid = '0;
  logic [NQ*CLS_W-1:0]    q_class = '0;
  logic [NQ*NS*TAG_W-1:0] q_src = '0;
  logic [NQ*NS-1:0]       q_src_en = '0;
  logic [NQ-1:0]          q_stall;
  logic [CNT_W-1:0]       cycle_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lat_scoreboard #(
    .NUM_TAGS (NUM_TAGS), .CNT_W (CNT_W), .NQ (NQ), .NS (NS)
  ) dut (
    .clk (clk), .rst (rst), .flush (flush),
    .disp_valid (disp_valid), .disp_tag (disp_tag), .disp_class (disp_class),
    .q_valid (q_valid), .q_class (q_class), .q_src (q_src), .q_src_en (q_src_en),
    .q_stall (q_stall), .cycle_o (cycle_o)
  );

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic set_q(input int p, input logic [CLS_W-1:0] cls,
                       input int s0, input int s1, input logic [NS-1:0] en);
    q_valid[p]                        = 1'b1;
    q_class[p*CLS_W +: CLS_W]         = cls;
    q_src[(p*NS+0)*TAG_W +: TAG_W]    = TAG_W'(s0);
    q_src[(p*NS+1)*TAG_W +: TAG_W]    = TAG_W'(s1);
    q_src_en[p*NS +: NS]              = en;
  endtask

  task automatic clr_q();
    q_valid  = '0;
    q_src_en = '0;
  endtask

  // Drive one dispatch; returns at the falling edge after it was sampled
  task automatic disp_edge(input int tag, input logic [CLS_W-1:0] cls);
    disp_valid = 1'b1;
    disp_tag   = TAG_W'(tag);
    disp_class = cls;
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  // Query tag on port 0 at d edges after the last dispatch
  task automatic probe(input int tag, input logic [CLS_W-1:0] cons, input int d,
                       input int exp, input string req);
    repeat (d - 1) @(negedge clk);
    set_q(0, cons, tag, 0, 2'b01);
    @(negedge clk);
    chk(req, int'(q_stall[0]), exp);
    clr_q();
  endtask

  // Stall one cycle before the latency, ready exactly at it
  task automatic pair(input logic [CLS_W-1:0] prod, input logic [CLS_W-1:0] cons,
                      input int lat, input string req);
    disp_edge(5, prod);
    repeat (lat - 2) @(negedge clk);
    set_q(0, cons, 5, 0, 2'b01);
    @(negedge clk);
    chk({req, " before latency"}, int'(q_stall[0]), 1);
    @(negedge clk);
    chk({req, " at latency"}, int'(q_stall[0]), 0);
    clr_q();
  endtask

  task automatic t_reset();
    int c0;
    chk("R1 stall in reset", int'(q_stall), 0);
    chk("R11 counter in reset", int'(cycle_o), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    c0 = int'(cycle_o);
    @(negedge clk);
    chk("R11 counter step", int'(cycle_o), (c0 + 1) % 256);
    set_q(0, OPC_ALU, 3, 17, 2'b11);
    @(negedge clk);
    chk("R1 ready after reset", int'(q_stall[0]), 0);
    clr_q();
  endtask

  task automatic t_base();
    pair(OPC_ALU,       OPC_ALU, 2,  "R2 alu");
    pair(OPC_LOAD,      OPC_ALU, 4,  "R2 load");
    pair(OPC_LOAD_SP,   OPC_ALU, 7,  "R2 sp load");
    pair(OPC_MUL,       OPC_ALU, 5,  "R2 mul");
    pair(OPC_MUL_REC,   OPC_ALU, 5,  "R2 mul rec");
    pair(OPC_DIV,       OPC_ALU, 12, "R2 div");
    pair(OPC_DIV_REC,   OPC_ALU, 12, "R2 div rec");
    pair(OPC_MMA,       OPC_ALU, 9,  "R2 mma");
    pair(OPC_ST_UPD,    OPC_ALU, 2,  "R2 store update");
    pair(OPC_SHIFT_REC, OPC_ALU, 3,  "R2 shift rec");
    pair(OPC_CR_LOGIC,  OPC_ALU, 2,  "R2 cr logic");
    pair(OPC_CR_MOVE,   OPC_ALU, 2,  "R2 cr move");
  endtask

  task automatic t_overrides();
    pair(OPC_MUL,       OPC_MUL,      4,  "R4 mul to mul");
    pair(OPC_MUL_REC,   OPC_MUL,      4,  "R4 mul rec to mul");
    pair(OPC_MUL,       OPC_MUL_REC,  4,  "R4 mul to mul rec");
    pair(OPC_MMA,       OPC_MMA,      4,  "R5 mma to mma");
    pair(OPC_MMA,       OPC_MUL,      9,  "R5 mma default");
    pair(OPC_ALU,       OPC_CR_LOGIC, 4,  "R6 alu to cr logic");
    pair(OPC_ALU,       OPC_CR_MOVE,  4,  "R6 alu to cr move");
    pair(OPC_SHIFT_REC, OPC_CR_MOVE,  5,  "R6 shift rec to cr");
    pair(OPC_LOAD,      OPC_CR_LOGIC, 4,  "R6 load to cr default");
    pair(OPC_MUL_REC,   OPC_CR_MOVE,  7,  "R7 mul rec to cr");
    pair(OPC_MUL,       OPC_CR_LOGIC, 5,  "R7 plain mul to cr default");
    pair(OPC_DIV_REC,   OPC_CR_LOGIC, 14, "R7 div rec to cr");
    pair(OPC_DIV,       OPC_CR_LOGIC, 12, "R7 plain div to cr default");
  endtask

  task automatic t_none();
    disp_edge(9, OPC_DIV);
    disp_edge(9, OPC_NONE);
    probe(9, OPC_ALU, 2, 1, "R3 store class keeps divide");
    disp_edge(10, OPC_DIV);
    disp_edge(10, 4'd14);
    probe(10, OPC_ALU, 2, 1, "R3 code 14 keeps divide");
    repeat (12) @(negedge clk);
    disp_edge(11, OPC_NONE);
    probe(11, OPC_ALU, 1, 0, "R3 store class on ready tag");
  endtask

  task automatic t_replace();
    disp_edge(4, OPC_DIV);
    disp_edge(4, OPC_ALU);
    set_q(0, OPC_ALU, 4, 0, 2'b01);
    @(negedge clk);
    chk("R9 newer alu pending", int'(q_stall[0]), 1);
    @(negedge clk);
    chk("R9 newer alu replaces divide", int'(q_stall[0]), 0);
    clr_q();
  endtask

  task automatic t_sources();
    repeat (16) @(negedge clk);
    disp_edge(20, OPC_DIV);
    set_q(1, OPC_ALU, 21, 20, 2'b01);
    set_q(0, OPC_ALU, 20, 21, 2'b01);
    @(negedge clk);
    chk("R8 disabled pending source ignored", int'(q_stall[1]), 0);
    chk("R8 port 0 pending source", int'(q_stall[0]), 1);
    set_q(1, OPC_ALU, 21, 20, 2'b11);
    @(negedge clk);
    chk("R8 second source pending", int'(q_stall[1]), 1);
    q_valid[1] = 1'b0;
    @(negedge clk);
    chk("R8 invalid port no stall", int'(q_stall[1]), 0);
    clr_q();
  endtask

  task automatic t_same_edge();
    repeat (16) @(negedge clk);
    set_q(0, OPC_ALU, 6, 0, 2'b01);
    disp_edge(6, OPC_ALU);
    chk("R10 same edge dispatch stalls", int'(q_stall[0]), 1);
    clr_q();
  endtask

  task automatic t_flush();
    disp_edge(7, OPC_DIV);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    probe(7, OPC_ALU, 1, 0, "R1 flush clears divide");
    flush = 1'b1;
    disp_edge(8, OPC_MUL);
    flush = 1'b0;
    probe(8, OPC_MUL, 1, 0, "R1 dispatch with flush dropped");
  endtask

  task automatic t_wrap();
    disp_edge(3, OPC_DIV_REC);
    probe(3, OPC_CR_LOGIC, 261, 0, "R12 wrapped counter reads ready");
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_base();
    t_overrides();
    t_none();
    t_replace();
    t_sources();
    t_same_edge();
    t_flush();
    t_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule